// File: doc/BRIEF.md
# Short-Packet Framer and Deframer with Dual-Seed CRC16

This block sits between a host and a byte-wide modem data path of a short-packet radio link. On the transmit side the host loads payload bytes into a 16-entry transmit FIFO, then starts a packet with a length. The block emits a start-marker beat, the length byte, the payload drained from the FIFO and, when CRC is on, a 16-bit CRC. The CRC seed is either a programmable value or zero.

On the receive side a start-marker pulse from the demodulator opens a packet. The next byte is taken as the payload length, and the following bytes are written into a 16-entry receive FIFO. When CRC is on, two trailing bytes are compared against CRCs run from the programmed seed and from zero. Either match marks the packet good.

Level interrupts on both FIFOs let the host refill or drain mid-packet, so packets of up to 40 payload bytes pass through the 16-byte buffers.

Top module: `pkt_framer`

## Requirements
- R1: A transmit frame is a sequence of beats, each transferred when `tx_valid_o` and `tx_ready_i` are both high. The beats are a marker beat (`tx_sop_o`=1, byte 0x00), the length byte, the payload in FIFO order, then the CRC low byte and then the CRC high byte when CRC is on. Only the marker beat has `tx_sop_o` set.
- R2: The CRC uses polynomial x^16+x^15+x^2+1, with bits fed least-significant first into a right-shifting register (reflected constant 0xA001) and no final inversion. The transmit CRC starts from `crc_seed_i`, or from zero when `tx_zero_seed_i` is 1 at start.
- R3: With CRC off, the frame ends after the last payload beat. `tx_done_o` pulses for one cycle after the final beat of every frame.
- R4: While `tx_ready_i` is low, the current beat is held unchanged. In the payload phase, `tx_valid_o` stays low while the transmit FIFO is empty. Bytes pushed during transmission stream out, so a 40-byte payload passes through the 16-entry FIFO.
- R5: A start request with a length above 40, or while a frame is in progress, is ignored.
- R6: After `rx_sop_i`, the first valid byte is the length. The next `length` bytes are written to the receive FIFO in order. End of packet (`rx_done_o` one-cycle pulse) follows `length`+2 bytes with CRC on, or `length` bytes with CRC off. Later bytes are not written.
- R7: `rx_crc_ok_o` is 1 after a packet whose received CRC (low byte first) equals the CRC from the seed or from zero, and 0 otherwise. With CRC off it is 1.
- R8: A length byte above 40 sets `rx_len_err_o`, writes no data and gives no `rx_done_o`. The next `rx_sop_i` clears it.
- R9: A payload byte arriving while the receive FIFO holds 16 entries is dropped, and `rx_ovf_o` is set. `rx_ovf_o` stays set until `rx_ovf_clr_i`.
- R10: `irq_tx_space_o` is 1 when the transmit FIFO has at least 8 free entries. `irq_rx_level_o` is 1 when the receive FIFO holds at least 8 bytes.
- R11: An `rx_sop_i` in the middle of a packet restarts reception with the next byte as length. Bytes already written stay in the FIFO.
- R12: After reset both FIFOs are empty, no beat is offered, and all receive status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_en_i | input | 1 | Append/check CRC, latched at packet start |
| crc_seed_i | input | 16 | Programmable CRC start value |
| tx_zero_seed_i | input | 1 | Transmit CRC starts from zero instead of the seed |
| tx_wr_i | input | 1 | Push a byte into the transmit FIFO |
| tx_wdata_i | input | 8 | Transmit FIFO write data |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_start_i | input | 1 | Start a frame |
| tx_len_i | input | 8 | Payload length for the frame |
| tx_busy_o | output | 1 | Frame in progress |
| tx_byte_o | output | 8 | Outgoing beat data |
| tx_sop_o | output | 1 | Current beat is the start marker |
| tx_valid_o | output | 1 | Beat offered |
| tx_ready_i | input | 1 | Beat accepted |
| tx_done_o | output | 1 | Frame complete pulse |
| rx_sop_i | input | 1 | Start marker detected |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_rd_i | input | 1 | Pop the receive FIFO |
| rx_rdata_o | output | 8 | Receive FIFO head |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_len_o | output | 8 | Length of the current packet |
| rx_done_o | output | 1 | End-of-packet pulse |
| rx_crc_ok_o | output | 1 | Last packet passed the CRC check |
| rx_len_err_o | output | 1 | Length byte out of range |
| rx_ovf_o | output | 1 | Sticky receive FIFO overflow |
| rx_ovf_clr_i | input | 1 | Clear the overflow flag |
| irq_tx_space_o | output | 1 | Transmit FIFO has room for 8 bytes |
| irq_rx_level_o | output | 1 | Receive FIFO holds 8 bytes or more |

## Verification
Transmit frames are driven with payloads from zero to forty bytes and with the sink always ready or randomly stalling. Seeded, zero-seeded and CRC-off frames separate the two seed paths and the frame end. A frame whose FIFO is held back mid-payload, and a 40-byte frame refilled on the fly, show stalling on an empty FIFO apart from streaming. Received packets carry seed-based, zero-based and corrupted CRCs, so each check path is tried alone. Directed cases cover an over-long length byte, a restart marker mid-packet, trailing junk after a CRC-off packet and an undrained 20-byte packet, which overflow and the sticky flag reveal.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_SOP, TX_LEN, TX_PAY, TX_CRCL, TX_CRCH
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_LEN, RX_PAY, RX_CRCL, RX_CRCH
  } rx_state_e;

  // reflected x^16+x^15+x^2+1, lsb first, no final xor
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = count_q == CW'(DEPTH);
  assign empty_o = count_q == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> full_o);
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import framer_pkg::*;
#(
  parameter int MAX_LEN = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  len_i,
  input  logic        crc_en_i,
  input  logic [15:0] seed_i,
  input  logic        zero_seed_i,
  input  logic        fifo_empty_i,
  input  logic [7:0]  fifo_data_i,
  output logic        fifo_pop_o,
  output logic [7:0]  byte_o,
  output logic        sop_o,
  output logic        valid_o,
  input  logic        ready_i,
  output logic        busy_o,
  output logic        done_o
);
  tx_state_e   state_q;
  logic [7:0]  len_q, left_q;
  logic [15:0] crc_q;
  logic        crc_en_q, done_q, xfer;

  always_comb begin
    valid_o = (state_q != TX_IDLE) && !(state_q == TX_PAY && fifo_empty_i);
    sop_o   = state_q == TX_SOP;
    case (state_q)
      TX_LEN:  byte_o = len_q;
      TX_PAY:  byte_o = fifo_data_i;
      TX_CRCL: byte_o = crc_q[7:0];
      TX_CRCH: byte_o = crc_q[15:8];
      default: byte_o = 8'h00;
    endcase
  end

  assign xfer       = valid_o && ready_i;
  assign fifo_pop_o = xfer && state_q == TX_PAY;
  assign busy_o     = state_q != TX_IDLE;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      len_q    <= '0;
      left_q   <= '0;
      crc_q    <= '0;
      crc_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        TX_IDLE: if (start_i && len_i <= 8'(MAX_LEN)) begin
          state_q  <= TX_SOP;
          len_q    <= len_i;
          left_q   <= len_i;
          crc_q    <= zero_seed_i ? 16'h0000 : seed_i;
          crc_en_q <= crc_en_i;
        end
        TX_SOP: if (xfer) state_q <= TX_LEN;
        TX_LEN: if (xfer) begin
          if (left_q != 8'd0) state_q <= TX_PAY;
          else if (crc_en_q)  state_q <= TX_CRCL;
          else begin
            state_q <= TX_IDLE;
            done_q  <= 1'b1;
          end
        end
        TX_PAY: if (xfer) begin
          crc_q  <= crc16_byte(crc_q, fifo_data_i);
          left_q <= left_q - 1'b1;
          if (left_q == 8'd1) begin
            if (crc_en_q) state_q <= TX_CRCL;
            else begin
              state_q <= TX_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        TX_CRCL: if (xfer) state_q <= TX_CRCH;
        TX_CRCH: if (xfer) begin
          state_q <= TX_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  a_r4_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(byte_o) && $stable(sop_o));
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_len_after_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o && ready_i |=> !sop_o && valid_o);
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import framer_pkg::*;
#(
  parameter int MAX_LEN = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sop_i,
  input  logic        valid_i,
  input  logic [7:0]  byte_i,
  input  logic        crc_en_i,
  input  logic [15:0] seed_i,
  input  logic        fifo_full_i,
  output logic        push_o,
  output logic [7:0]  push_data_o,
  input  logic        ovf_clr_i,
  output logic [7:0]  len_o,
  output logic        done_o,
  output logic        crc_ok_o,
  output logic        len_err_o,
  output logic        ovf_o
);
  rx_state_e   state_q;
  logic [7:0]  len_q, left_q, lo_q;
  logic [15:0] crc_s_q, crc_z_q;
  logic        crc_en_q, done_q, ok_q, len_err_q, ovf_q;
  logic        pay_beat, crc_match;

  assign pay_beat    = state_q == RX_PAY && valid_i && !sop_i;
  assign push_o      = pay_beat && !fifo_full_i;
  assign push_data_o = byte_i;
  assign crc_match   = ({byte_i, lo_q} == crc_s_q) || ({byte_i, lo_q} == crc_z_q);
  assign len_o       = len_q;
  assign done_o      = done_q;
  assign crc_ok_o    = ok_q;
  assign len_err_o   = len_err_q;
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      len_q     <= '0;
      left_q    <= '0;
      lo_q      <= '0;
      crc_s_q   <= '0;
      crc_z_q   <= '0;
      crc_en_q  <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      len_err_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pay_beat && fifo_full_i) ovf_q <= 1'b1;
      else if (ovf_clr_i)          ovf_q <= 1'b0;
      if (sop_i) begin
        state_q   <= RX_LEN;
        crc_s_q   <= seed_i;
        crc_z_q   <= 16'h0000;
        crc_en_q  <= crc_en_i;
        ok_q      <= 1'b0;
        len_err_q <= 1'b0;
      end else if (valid_i) begin
        case (state_q)
          RX_LEN: begin
            if (byte_i > 8'(MAX_LEN)) begin
              len_err_q <= 1'b1;
              state_q   <= RX_IDLE;
            end else begin
              len_q  <= byte_i;
              left_q <= byte_i;
              if (byte_i != 8'd0) state_q <= RX_PAY;
              else if (crc_en_q)  state_q <= RX_CRCL;
              else begin
                state_q <= RX_IDLE;
                done_q  <= 1'b1;
                ok_q    <= 1'b1;
              end
            end
          end
          RX_PAY: begin
            crc_s_q <= crc16_byte(crc_s_q, byte_i);
            crc_z_q <= crc16_byte(crc_z_q, byte_i);
            left_q  <= left_q - 1'b1;
            if (left_q == 8'd1) begin
              if (crc_en_q) state_q <= RX_CRCL;
              else begin
                state_q <= RX_IDLE;
                done_q  <= 1'b1;
                ok_q    <= 1'b1;
              end
            end
          end
          RX_CRCL: begin
            lo_q    <= byte_i;
            state_q <= RX_CRCH;
          end
          RX_CRCH: begin
            ok_q    <= crc_match;
            done_q  <= 1'b1;
            state_q <= RX_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);
  a_r8_no_push_on_len_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !push_o);
  a_r8_no_done_on_len_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !done_o);
  a_r7_ok_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sop_i |=> done_o || $stable(crc_ok_o));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int DEPTH   = 16,
  parameter int MAX_LEN = 40,
  parameter int IRQ_LVL = 8,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        crc_en_i,
  input  logic [15:0] crc_seed_i,
  input  logic        tx_zero_seed_i,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_wdata_i,
  output logic        tx_full_o,
  input  logic        tx_start_i,
  input  logic [7:0]  tx_len_i,
  output logic        tx_busy_o,
  output logic [7:0]  tx_byte_o,
  output logic        tx_sop_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic        tx_done_o,
  input  logic        rx_sop_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_rd_i,
  output logic [7:0]  rx_rdata_o,
  output logic        rx_empty_o,
  output logic [7:0]  rx_len_o,
  output logic        rx_done_o,
  output logic        rx_crc_ok_o,
  output logic        rx_len_err_o,
  output logic        rx_ovf_o,
  input  logic        rx_ovf_clr_i,
  output logic        irq_tx_space_o,
  output logic        irq_rx_level_o
);
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_empty, tx_pop, rx_full, rx_push;
  logic [7:0]    tx_head, rx_push_data;

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_wr_i),  .data_i (tx_wdata_i),
    .pop_i  (tx_pop),   .data_o (tx_head),
    .count_o(tx_count), .full_o (tx_full_o), .empty_o(tx_empty)
  );

  tx_framer #(.MAX_LEN(MAX_LEN)) u_tx (
    .clk_i, .rst_ni,
    .start_i     (tx_start_i),
    .len_i       (tx_len_i),
    .crc_en_i    (crc_en_i),
    .seed_i      (crc_seed_i),
    .zero_seed_i (tx_zero_seed_i),
    .fifo_empty_i(tx_empty),
    .fifo_data_i (tx_head),
    .fifo_pop_o  (tx_pop),
    .byte_o      (tx_byte_o),
    .sop_o       (tx_sop_o),
    .valid_o     (tx_valid_o),
    .ready_i     (tx_ready_i),
    .busy_o      (tx_busy_o),
    .done_o      (tx_done_o)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),  .data_i (rx_push_data),
    .pop_i  (rx_rd_i),  .data_o (rx_rdata_o),
    .count_o(rx_count), .full_o (rx_full), .empty_o(rx_empty_o)
  );

  rx_deframer #(.MAX_LEN(MAX_LEN)) u_rx (
    .clk_i, .rst_ni,
    .sop_i      (rx_sop_i),
    .valid_i    (rx_valid_i),
    .byte_i     (rx_byte_i),
    .crc_en_i   (crc_en_i),
    .seed_i     (crc_seed_i),
    .fifo_full_i(rx_full),
    .push_o     (rx_push),
    .push_data_o(rx_push_data),
    .ovf_clr_i  (rx_ovf_clr_i),
    .len_o      (rx_len_o),
    .done_o     (rx_done_o),
    .crc_ok_o   (rx_crc_ok_o),
    .len_err_o  (rx_len_err_o),
    .ovf_o      (rx_ovf_o)
  );

  assign irq_tx_space_o = tx_count <= CW'(DEPTH - IRQ_LVL);
  assign irq_rx_level_o = rx_count >= CW'(IRQ_LVL);

  a_r10_full_no_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> !irq_tx_space_o);
  a_r10_empty_no_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !irq_rx_level_o);
endmodule

// File: tb/pkt_framer_tb_top.sv
module pkt_framer_tb_top;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        crc_en_i = 1'b1, tx_zero_seed_i = 1'b0;
  logic [15:0] crc_seed_i = SEED;
  logic        tx_wr_i = 1'b0, tx_start_i = 1'b0, tx_ready_i = 1'b0;
  logic [7:0]  tx_wdata_i = '0, tx_len_i = '0;
  logic        tx_full_o, tx_busy_o, tx_sop_o, tx_valid_o, tx_done_o;
  logic [7:0]  tx_byte_o;
  logic        rx_sop_i = 1'b0, rx_valid_i = 1'b0, rx_rd_i = 1'b0, rx_ovf_clr_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic [7:0]  rx_rdata_o, rx_len_o;
  logic        rx_empty_o, rx_done_o, rx_crc_ok_o, rx_len_err_o, rx_ovf_o;
  logic        irq_tx_space_o, irq_rx_level_o;

  int checks = 0, errors = 0;
  bit ended = 0;

  logic [7:0] tpl [40];
  logic [7:0] tb_byte [64];
  bit         tb_sop [64];
  int         tb_n;
  logic [7:0] rpl [48];
  logic [8:0] rstream [64];
  int         rn;
  logic [7:0] rgot [64];
  int         rgot_n;
  logic [7:0] cbuf [48];

  always #4 clk = ~clk;

  pkt_framer dut_i (.clk_i(clk), .*);

  function automatic logic [15:0] ref_crc(input logic [15:0] init, input int n);
    logic [15:0] c;
    c = init;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ cbuf[k][b];
        c  = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- transmit ----------------
  task automatic tx_run(input int len, input bit cen, input bit zs, input int preload,
                        input int hold, input bit rnd_ready, input bit poke, input string req);
    int loaded, exp_n, bad;
    bit done;
    logic [15:0] c;
    loaded = 0; done = 0; tb_n = 0; bad = 0;
    for (int k = 0; k < len; k++) tpl[k] = 8'($urandom);
    @(negedge clk);
    crc_en_i = cen; tx_zero_seed_i = zs; tx_ready_i = 1'b0;
    while (loaded < preload) begin
      tx_wr_i = 1'b1; tx_wdata_i = tpl[loaded]; loaded++;
      @(negedge clk);
    end
    tx_wr_i = 1'b0;
    chk(irq_tx_space_o == ((16 - preload) >= 8), "R10 tx space irq", irq_tx_space_o,
        (16 - preload) >= 8);
    tx_start_i = 1'b1; tx_len_i = 8'(len);
    @(negedge clk);
    tx_start_i = 1'b0;
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      @(negedge clk);
      if (tx_done_o) begin
        done = 1;
      end else begin
        if (cyc == 15 && hold > 15)
          chk(tx_valid_o == 1'b0, "R4 stall on empty fifo", tx_valid_o, 0);
        tx_ready_i = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
        if (cyc >= hold && loaded < len && !tx_full_o) begin
          tx_wr_i = 1'b1; tx_wdata_i = tpl[loaded]; loaded++;
        end else tx_wr_i = 1'b0;
        tx_start_i = poke && cyc == 6;
        tx_len_i   = 8'd2;
        if (tx_valid_o && tx_ready_i && tb_n < 64) begin
          tb_byte[tb_n] = tx_byte_o; tb_sop[tb_n] = tx_sop_o; tb_n++;
        end
      end
    end
    tx_ready_i = 1'b0; tx_wr_i = 1'b0; tx_start_i = 1'b0;
    exp_n = 2 + len + (cen ? 2 : 0);
    chk(done, {req, " R3 done pulse"}, done, 1);
    chk(tb_n == exp_n, {req, " R1 beat count"}, tb_n, exp_n);
    if (tb_n == exp_n) begin
      for (int k = 0; k < len; k++) cbuf[k] = tpl[k];
      c = ref_crc(zs ? 16'h0000 : SEED, len);
      chk(tb_sop[0] && tb_byte[0] == 8'h00, {req, " R1 marker beat"}, tb_byte[0], 0);
      chk(!tb_sop[1] && tb_byte[1] == 8'(len), {req, " R1 length beat"}, tb_byte[1], len);
      for (int k = 0; k < len; k++)
        if (tb_byte[2+k] !== tpl[k] || tb_sop[2+k]) bad++;
      chk(bad == 0, {req, " R1 payload order"}, bad, 0);
      if (cen) chk({tb_byte[exp_n-1], tb_byte[exp_n-2]} == c, {req, " R2 crc value"},
                   {tb_byte[exp_n-1], tb_byte[exp_n-2]}, c);
    end
  endtask

  // ---------------- receive ----------------
  task automatic build_rx(input int len, input bit cen, input int mode);
    logic [15:0] c;
    rn = 0;
    rstream[rn++] = 9'h100;
    rstream[rn++] = {1'b0, 8'(len)};
    for (int k = 0; k < len; k++) begin
      rpl[k] = 8'($urandom); cbuf[k] = rpl[k];
      rstream[rn++] = {1'b0, rpl[k]};
    end
    if (cen) begin
      c = ref_crc(mode == 1 ? 16'h0000 : SEED, len);
      if (mode == 2) c = c ^ 16'h0040;
      rstream[rn++] = {1'b0, c[7:0]};
      rstream[rn++] = {1'b0, c[15:8]};
    end
  endtask

  task automatic rx_run(input bit cen, input bit drain, output int dones);
    dones = 0; rgot_n = 0;
    @(negedge clk);
    crc_en_i = cen;
    for (int cyc = 0; cyc < 2 * rn + 8; cyc++) begin
      @(negedge clk);
      if (rx_done_o) dones++;
      if (cyc % 2 == 0 && cyc / 2 < rn) begin
        rx_sop_i   = rstream[cyc/2][8];
        rx_valid_i = !rstream[cyc/2][8];
        rx_byte_i  = rstream[cyc/2][7:0];
      end else begin
        rx_sop_i = 1'b0; rx_valid_i = 1'b0;
      end
      if (drain && !rx_empty_o) begin
        rx_rd_i = 1'b1; rgot[rgot_n++] = rx_rdata_o;
      end else rx_rd_i = 1'b0;
    end
    @(negedge clk);
    rx_sop_i = 1'b0; rx_valid_i = 1'b0; rx_rd_i = 1'b0;
  endtask

  task automatic read_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!rx_empty_o) begin
        rx_rd_i = 1'b1; rgot[rgot_n++] = rx_rdata_o;
      end else rx_rd_i = 1'b0;
    end
    @(negedge clk);
    rx_rd_i = 1'b0;
  endtask

  task automatic check_rx_data(input int n, input string req);
    int bad;
    bad = 0;
    chk(rgot_n == n, {req, " byte count"}, rgot_n, n);
    for (int k = 0; k < n && k < rgot_n; k++) if (rgot[k] !== rpl[k]) bad++;
    chk(bad == 0, {req, " byte order"}, bad, 0);
  endtask

  task automatic rx_simple(input int len, input bit cen, input int mode, input string req);
    int dn;
    build_rx(len, cen, mode);
    rx_run(cen, 1'b1, dn);
    read_n(20);
    chk(dn == 1, {req, " R6 one done"}, dn, 1);
    chk(rx_len_o == 8'(len), {req, " R6 length"}, rx_len_o, len);
    chk(rx_crc_ok_o == (mode != 2), {req, " R7 crc verdict"}, rx_crc_ok_o, mode != 2);
    check_rx_data(len, {req, " R6"});
  endtask

  initial begin
    int dn, l;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!tx_valid_o && !tx_busy_o, "R12 tx idle", tx_valid_o, 0);
    chk(rx_empty_o && !irq_rx_level_o, "R12 rx empty", rx_empty_o, 1);
    chk(irq_tx_space_o && !tx_full_o, "R12 tx fifo empty", irq_tx_space_o, 1);
    chk(!rx_ovf_o && !rx_len_err_o && !rx_crc_ok_o && !rx_done_o, "R12 rx flags",
        {rx_ovf_o, rx_len_err_o, rx_crc_ok_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_valid_o && rx_empty_o && !rx_ovf_o, "R12 after release", tx_valid_o, 0);

    // transmit directed
    tx_run(5, 1, 0, 5, 0, 0, 0, "R2 seeded");
    tx_run(5, 1, 1, 5, 0, 0, 0, "R2 zero seed");
    tx_run(3, 0, 0, 3, 0, 0, 0, "R3 crc off");
    tx_run(0, 1, 0, 0, 0, 0, 0, "R1 empty payload");
    tx_run(6, 1, 0, 2, 20, 0, 0, "R4 starved");
    tx_run(40, 1, 0, 16, 0, 1, 1, "R4 R5 40-byte stream");
    tx_run(9, 1, 0, 9, 0, 1, 0, "R10 nine loaded");
    // R5 over-long start
    @(negedge clk);
    tx_start_i = 1'b1; tx_len_i = 8'd41;
    @(negedge clk);
    tx_start_i = 1'b0;
    @(negedge clk);
    chk(!tx_busy_o && !tx_valid_o, "R5 length 41 ignored", tx_busy_o, 0);
    for (int i = 0; i < 4; i++) begin
      l = $urandom % 41;
      tx_run(l, 1'($urandom), 1'($urandom), (l > 16) ? 16 : l, 0, 1, 0, "R1 random tx");
    end

    // receive directed
    rx_simple(4, 1, 0, "R7 seed crc");
    rx_simple(4, 1, 1, "R7 zero crc");
    rx_simple(4, 1, 2, "R7 bad crc");
    rx_simple(40, 1, 0, "R6 40-byte drain");
    rx_simple(0, 1, 1, "R6 empty payload");

    // R6 crc off, trailing junk not written
    build_rx(3, 0, 0);
    rstream[rn++] = 9'h0AA;
    rstream[rn++] = 9'h055;
    rx_run(0, 1, dn);
    read_n(4);
    chk(dn == 1, "R6 crc-off done", dn, 1);
    chk(rx_crc_ok_o, "R7 crc-off ok", rx_crc_ok_o, 1);
    check_rx_data(3, "R6 crc-off junk");

    // R10 rx level
    build_rx(10, 1, 0);
    rx_run(1, 0, dn);
    chk(irq_rx_level_o, "R10 rx level at 10", irq_rx_level_o, 1);
    read_n(3);
    chk(!irq_rx_level_o, "R10 rx level at 7", irq_rx_level_o, 0);
    read_n(10);
    check_rx_data(10, "R10 rx");

    // R9 overflow
    build_rx(20, 1, 0);
    rx_run(1, 0, dn);
    chk(rx_ovf_o, "R9 overflow set", rx_ovf_o, 1);
    chk(rx_crc_ok_o && dn == 1, "R9 crc over full packet", rx_crc_ok_o, 1);
    repeat (5) @(negedge clk);
    chk(rx_ovf_o, "R9 overflow sticky", rx_ovf_o, 1);
    read_n(20);
    check_rx_data(16, "R9 kept first 16");
    rx_ovf_clr_i = 1'b1;
    @(negedge clk);
    rx_ovf_clr_i = 1'b0;
    @(negedge clk);
    chk(!rx_ovf_o, "R9 overflow cleared", rx_ovf_o, 1'b0);

    // R8 length error
    rn = 0;
    rstream[rn++] = 9'h100;
    rstream[rn++] = 9'd41;
    for (int k = 0; k < 3; k++) rstream[rn++] = 9'h033;
    rx_run(1, 0, dn);
    chk(rx_len_err_o, "R8 len error set", rx_len_err_o, 1);
    chk(dn == 0, "R8 no done", dn, 0);
    chk(rx_empty_o, "R8 nothing written", rx_empty_o, 1);
    rx_simple(2, 1, 0, "R8 next packet");
    chk(!rx_len_err_o, "R8 cleared by sop", rx_len_err_o, 0);

    // R11 restart mid-packet
    rn = 0;
    rstream[rn++] = 9'h100;
    rstream[rn++] = 9'd5;
    rstream[rn++] = 9'h011;
    rstream[rn++] = 9'h022;
    begin
      logic [15:0] c;
      rpl[0] = 8'h11; rpl[1] = 8'h22;
      rpl[2] = 8'h3C; rpl[3] = 8'hC3; rpl[4] = 8'h7E;
      for (int k = 0; k < 3; k++) cbuf[k] = rpl[2+k];
      c = ref_crc(SEED, 3);
      rstream[rn++] = 9'h100;
      rstream[rn++] = 9'd3;
      for (int k = 0; k < 3; k++) rstream[rn++] = {1'b0, rpl[2+k]};
      rstream[rn++] = {1'b0, c[7:0]};
      rstream[rn++] = {1'b0, c[15:8]};
    end
    rx_run(1, 1, dn);
    read_n(4);
    chk(dn == 1 && rx_len_o == 8'd3, "R11 restart length", rx_len_o, 3);
    chk(rx_crc_ok_o, "R11 restart crc", rx_crc_ok_o, 1);
    check_rx_data(5, "R11 stale plus new");

    for (int i = 0; i < 6; i++) begin
      l = $urandom % 41;
      rx_simple(l, 1, $urandom % 3, "R6 R7 random rx");
    end

    finish_run();
  end
endmodule